// File: doc/BRIEF.md
# Saturating Packed Halfword Add/Subtract Unit

This unit is one execution-stage datapath of a 32-bit processor. It views each of its two word operands, called N and M, as a pair of signed halfword lanes. A 3-bit operation code selects one of four lane patterns. Two patterns are straight: both lanes add, or both lanes subtract. Two patterns are crossed: the low lane of N meets the high lane of M, and the high lane of N meets the low lane of M. Each lane result is clamped to the signed halfword range on its own, so a lane never wraps. The two lanes are then packed back into one word.

The instruction's 4-bit condition field arrives with the operands, together with a pass signal from an external condition evaluator. The result register is written only when the operation executes. Otherwise it keeps its previous value, so the write-back stage can treat the valid pulse as its register-file write enable. Operation codes 4 to 7 are reserved. They never write and they raise a one-cycle illegal-operation flag.

Top module: `phsat_unit`

## Requirements
- R1: Op code 0 sets low = Nlo + Mlo and high = Nhi + Mhi. Here lo is bits 15:0 and hi is bits 31:16, and every halfword is read as two's complement.
- R2: Op code 1 sets low = Nlo − Mhi and high = Nhi + Mlo.
- R3: Op code 2 sets low = Nlo + Mhi and high = Nhi − Mlo.
- R4: Op code 3 sets low = Nlo − Mlo and high = Nhi − Mhi.
- R5: A lane whose exact result is above 32767 yields 0x7FFF. When both addends of an add lane are non-negative, the lane's sign bit is never set.
- R6: A lane whose exact result is below −32768 yields 0x8000. The two lanes clamp independently of each other.
- R7: The result word is {high lane, low lane}: the high lane sits in bits 31:16 and the low lane in bits 15:0.
- R8: With condition field 0xE the operation executes whatever the pass input says.
- R9: With any other condition field the operation executes only when the pass input is 1. A skipped operation leaves res_valid low and res_data unchanged.
- R10: Op codes 4 to 7 set op_illegal in the next cycle, whatever the condition. They never set res_valid and never change res_data.
- R11: res_data and res_valid update on the first rising clock edge after in_valid is sampled high. res_valid is high for exactly one cycle per executed operation and stays low when in_valid is low.
- R12: A synchronous active-high rst clears res_valid, op_illegal and res_data to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Lane pattern; 4 to 7 reserved |
| cond_field | input | 4 | Condition field of the instruction; 0xE means always |
| cond_pass | input | 1 | Condition evaluator says the condition holds |
| opnd_n | input | 32 | First operand N |
| opnd_m | input | 32 | Second operand M |
| res_data | output | 32 | Registered packed result |
| res_valid | output | 1 | One-cycle write enable for res_data |
| op_illegal | output | 1 | One-cycle flag for a reserved op code |

## Verification
The hardest case to provoke is a crossed pattern where each lane clamps in the opposite direction in the same operation. The low lane must take its subtrahend from M's high half while the high lane overflows with M's low half. Vector entries place the extremes 0x7FFF and 0x8000 in the N halves and small values in the crossed M halves, so one lane clamps high and the other clamps low. The skip and illegal paths run right after a known result, so a held register is told apart from a rewritten one.

// File: rtl/phsat_pkg.sv
package phsat_pkg;

   typedef enum logic [2:0] {
      PH_ADD_ADD = 3'd0,
      PH_SUB_ADD = 3'd1,
      PH_ADD_SUB = 3'd2,
      PH_SUB_SUB = 3'd3
   } ph_op_e;

   localparam logic [3:0] PH_COND_ALWAYS = 4'hE;

   function automatic logic ph_op_legal(input logic [2:0] op);
      return (op[2] == 1'b0);
   endfunction

   // crossed patterns take M's opposite half into each lane
   function automatic logic ph_op_crossed(input logic [2:0] op);
      return (op == PH_SUB_ADD) || (op == PH_ADD_SUB);
   endfunction

   function automatic logic ph_lo_subtracts(input logic [2:0] op);
      return (op == PH_SUB_ADD) || (op == PH_SUB_SUB);
   endfunction

   function automatic logic ph_hi_subtracts(input logic [2:0] op);
      return (op == PH_ADD_SUB) || (op == PH_SUB_SUB);
   endfunction

endpackage

// File: rtl/phsat_route.sv
module phsat_route
   import phsat_pkg::*;
#(
   parameter int LANE_W = 16,
   localparam int DW = 2 * LANE_W
) (
   input  logic [2:0]        op_code,
   input  logic [DW-1:0]     opnd_n,
   input  logic [DW-1:0]     opnd_m,
   output logic [LANE_W-1:0] lo_a,
   output logic [LANE_W-1:0] lo_b,
   output logic              lo_sub,
   output logic [LANE_W-1:0] hi_a,
   output logic [LANE_W-1:0] hi_b,
   output logic              hi_sub
);
   logic [LANE_W-1:0] m_lo, m_hi;
   logic              crossed;

   always_comb begin
      m_lo    = opnd_m[LANE_W-1:0];
      m_hi    = opnd_m[DW-1:LANE_W];
      crossed = ph_op_crossed(op_code);
      lo_a    = opnd_n[LANE_W-1:0];
      hi_a    = opnd_n[DW-1:LANE_W];
      lo_b    = crossed ? m_hi : m_lo;
      hi_b    = crossed ? m_lo : m_hi;
      lo_sub  = ph_lo_subtracts(op_code);
      hi_sub  = ph_hi_subtracts(op_code);
   end
endmodule

// File: rtl/phsat_lane.sv
module phsat_lane #(
   parameter int LANE_W   = 16,
   parameter bit SATURATE = 1'b1,
   localparam int XW = LANE_W + 1
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic              sub,
   output logic [LANE_W-1:0] y
);
   localparam logic signed [XW-1:0] MAX_POS = XW'((2 ** (LANE_W - 1)) - 1);
   localparam logic signed [XW-1:0] MIN_NEG = -XW'(2 ** (LANE_W - 1));

   logic signed [XW-1:0] ax, bx, exact;

   always_comb begin
      ax    = signed'({a[LANE_W-1], a});
      bx    = signed'({b[LANE_W-1], b});
      exact = sub ? (ax - bx) : (ax + bx);
   end

   if (SATURATE) begin : g_clamp
      always_comb begin
         if (exact > MAX_POS)      y = MAX_POS[LANE_W-1:0];
         else if (exact < MIN_NEG) y = MIN_NEG[LANE_W-1:0];
         else                      y = exact[LANE_W-1:0];
      end
   end else begin : g_wrap
      always_comb y = exact[LANE_W-1:0];
   end
endmodule

// File: rtl/phsat_unit.sv
module phsat_unit
   import phsat_pkg::*;
#(
   parameter int LANE_W   = 16,
   parameter bit SATURATE = 1'b1,
   localparam int DW = 2 * LANE_W
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [2:0]    op_code,
   input  logic [3:0]    cond_field,
   input  logic          cond_pass,
   input  logic [DW-1:0] opnd_n,
   input  logic [DW-1:0] opnd_m,
   output logic [DW-1:0] res_data,
   output logic          res_valid,
   output logic          op_illegal
);
   if (LANE_W < 2) begin : g_bad_lane
      $error("phsat_unit: LANE_W must be at least 2");
   end

   logic [LANE_W-1:0] lo_a, lo_b, hi_a, hi_b, lo_y, hi_y;
   logic              lo_sub, hi_sub;
   logic              legal, executes, write_en;

   phsat_route #(.LANE_W(LANE_W)) u_route (
      .op_code(op_code), .opnd_n(opnd_n), .opnd_m(opnd_m),
      .lo_a(lo_a), .lo_b(lo_b), .lo_sub(lo_sub),
      .hi_a(hi_a), .hi_b(hi_b), .hi_sub(hi_sub)
   );

   phsat_lane #(.LANE_W(LANE_W), .SATURATE(SATURATE)) u_lo (
      .a(lo_a), .b(lo_b), .sub(lo_sub), .y(lo_y)
   );

   phsat_lane #(.LANE_W(LANE_W), .SATURATE(SATURATE)) u_hi (
      .a(hi_a), .b(hi_b), .sub(hi_sub), .y(hi_y)
   );

   always_comb begin
      legal    = ph_op_legal(op_code);
      executes = (cond_field == PH_COND_ALWAYS) || cond_pass;
      write_en = in_valid && legal && executes;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid  <= 1'b0;
         op_illegal <= 1'b0;
         res_data   <= '0;
      end else begin
         res_valid  <= write_en;
         op_illegal <= in_valid && !legal;
         if (write_en) res_data <= {hi_y, lo_y};
      end
   end
endmodule

// File: rtl/phsat_chk.sv
module phsat_chk #(
   parameter int LANE_W = 16,
   localparam int DW = 2 * LANE_W
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [2:0]    op_code,
   input logic [3:0]    cond_field,
   input logic          cond_pass,
   input logic [DW-1:0] opnd_n,
   input logic [DW-1:0] opnd_m,
   input logic [DW-1:0] res_data,
   input logic          res_valid,
   input logic          op_illegal
);
   localparam int SB = LANE_W - 1;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!res_valid && !op_illegal && res_data == '0)); // R12

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> $past(in_valid)); // R11

   AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !res_valid |-> $stable(res_data)); // R9

   AST_COND_FAIL_SKIPS: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && $past(cond_field) != 4'hE && !$past(cond_pass))
      |-> !res_valid); // R9

   AST_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && $past(cond_field) == 4'hE && !$past(op_code[2]))
      |-> res_valid); // R8

   AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      op_illegal |-> (!res_valid && $past(in_valid) && $past(op_code[2]))); // R10

   AST_NO_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
      (res_valid && $past(op_code) == 3'd0 && !$past(opnd_n[SB]) && !$past(opnd_m[SB]))
      |-> !res_data[SB]); // R5

   AST_NO_NEG_WRAP: assert property (@(posedge clk) disable iff (rst)
      (res_valid && $past(op_code) == 3'd0 && $past(opnd_n[SB]) && $past(opnd_m[SB]))
      |-> res_data[SB]); // R6
endmodule

bind phsat_unit phsat_chk #(.LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
   .cond_field(cond_field), .cond_pass(cond_pass), .opnd_n(opnd_n),
   .opnd_m(opnd_m), .res_data(res_data), .res_valid(res_valid),
   .op_illegal(op_illegal)
);

// File: tb/sim_phsat_unit.sv
module sim_phsat_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 11;
   localparam int WATCHDOG = 5000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [3:0]  cond_field = 4'hE;
   logic        cond_pass = 1'b0;
   logic [31:0] opnd_n = '0, opnd_m = '0;
   logic [31:0] res_data;
   logic        res_valid, op_illegal;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // {op, N, M, expected}
   localparam logic [98:0] VEC [NVEC] = '{
      {3'd0, 32'h0003_0005, 32'h0002_0001, 32'h0005_0006}, // R1
      {3'd1, 32'h0010_0020, 32'h0003_0004, 32'h0014_001D}, // R2
      {3'd2, 32'h0010_0020, 32'h0003_0004, 32'h000C_0023}, // R3
      {3'd3, 32'h0010_0020, 32'h0003_0004, 32'h000D_001C}, // R4
      {3'd0, 32'h7FFF_7000, 32'h0001_1000, 32'h7FFF_7FFF}, // R5
      {3'd3, 32'h8000_0000, 32'h0001_7FFF, 32'h8000_8001}, // R6
      {3'd1, 32'h7FFF_8000, 32'h0001_0001, 32'h7FFF_8000}, // R2 R5 R6 crossed
      {3'd2, 32'h8000_7FFF, 32'h0001_0001, 32'h8000_7FFF}, // R3 R5 R6 crossed
      {3'd3, 32'h0000_0000, 32'h8000_8000, 32'h7FFF_7FFF}, // R5
      {3'd0, 32'hFFFF_FFFE, 32'h0001_0003, 32'h0000_0001}, // R1 R7
      {3'd1, 32'h1234_0000, 32'hFFFF_0001, 32'h1235_0001}  // R7
   };

   phsat_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
      .cond_field(cond_field), .cond_pass(cond_pass), .opnd_n(opnd_n),
      .opnd_m(opnd_m), .res_data(res_data), .res_valid(res_valid),
      .op_illegal(op_illegal)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, the result is visible at the next falling edge
   task automatic issue(input logic [2:0] op, input logic [3:0] cf, input logic cp,
                        input logic [31:0] n, input logic [31:0] m);
      op_code = op; cond_field = cf; cond_pass = cp; opnd_n = n; opnd_m = m;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R12 valid after reset", {31'b0, res_valid}, 32'd0);
      check("R12 illegal after reset", {31'b0, op_illegal}, 32'd0);
      check("R12 data after reset", res_data, 32'd0);
      rst = 1'b0;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         issue(VEC[i][98:96], 4'hE, 1'b0, VEC[i][95:64], VEC[i][63:32]);
         check($sformatf("R1-R7 vector %0d valid (R11)", i), {31'b0, res_valid}, 32'd1);
         check($sformatf("R1-R7 vector %0d data", i), res_data, VEC[i][31:0]);
      end

      // R9: condition fails, register holds
      issue(3'd0, 4'h0, 1'b0, 32'h1, 32'h1);
      check("R9 skipped valid", {31'b0, res_valid}, 32'd0);
      check("R9 skipped data held", res_data, 32'h1235_0001);
      // R9: condition passes
      issue(3'd0, 4'h0, 1'b1, 32'h1, 32'h1);
      check("R9 passed valid", {31'b0, res_valid}, 32'd1);
      check("R9 passed data", res_data, 32'h0000_0002);
      // R8: always condition ignores pass input
      issue(3'd0, 4'hE, 1'b0, 32'h2, 32'h2);
      check("R8 always valid", {31'b0, res_valid}, 32'd1);
      check("R8 always data", res_data, 32'h0000_0004);
      // R10: reserved ops
      issue(3'd5, 4'hE, 1'b1, 32'h7, 32'h7);
      check("R10 illegal flag", {31'b0, op_illegal}, 32'd1);
      check("R10 no valid", {31'b0, res_valid}, 32'd0);
      check("R10 data held", res_data, 32'h0000_0004);
      issue(3'd7, 4'h3, 1'b0, 32'h7, 32'h7);
      check("R10 illegal despite failed cond", {31'b0, op_illegal}, 32'd1);
      check("R10 data held again", res_data, 32'h0000_0004);
      // R11: idle cycle, inputs change without strobe
      op_code = 3'd0; cond_field = 4'hE; opnd_n = 32'h9; opnd_m = 32'h9;
      @(negedge clk);
      check("R11 idle valid", {31'b0, res_valid}, 32'd0);
      check("R11 idle illegal", {31'b0, op_illegal}, 32'd0);
      check("R11 idle data", res_data, 32'h0000_0004);
      // R11: back-to-back
      op_code = 3'd0; cond_field = 4'hE; opnd_n = 32'h0001_0001; opnd_m = 32'h0001_0001;
      in_valid = 1'b1;
      @(negedge clk);
      check("R11 back-to-back first", res_data, 32'h0002_0002);
      op_code = 3'd3; opnd_n = 32'h0005_0005; opnd_m = 32'h0001_0002;
      @(negedge clk);
      in_valid = 1'b0;
      check("R11 back-to-back second", res_data, 32'h0004_0003);
      check("R11 back-to-back valid", {31'b0, res_valid}, 32'd1);
      @(negedge clk);
      check("R11 single-cycle pulse", {31'b0, res_valid}, 32'd0);
      // R12: reset mid-run
      rst = 1'b1;
      @(negedge clk);
      check("R12 mid-run data cleared", res_data, 32'd0);
      check("R12 mid-run valid cleared", {31'b0, res_valid}, 32'd0);
      rst = 1'b0;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule